// File: doc/BRIEF.md
# MDIO Management Master (Clause 22 / Clause 45)

This block is a register-mapped station-management master for Ethernet PHYs. Software sets a frame format bit, a port address with a register or device number, and a 16-bit write value. It then writes a start command carrying an access code. The block sends one complete management frame on MDC/MDIO. While the frame runs, a busy flag reads as 1. When a read frame ends, the 16 bits returned by the PHY are held in a read-data register.

In the Clause 45 format one command path serves three kinds of access. The write-data register holds the 16-bit register address for an address frame, and the data for a write frame. A Clause 45 register read is therefore two commands: an address command first, then a read command. MDC is derived from the system clock by an even divider and runs only while a frame is in progress. The master changes MDIO only on falling MDC edges and samples it on rising edges.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset, MDC and the MDIO output enable are 0, and every register reads 0: mode at 0x40, address at 0x44, write data at 0x48, read data at 0x4C and command at 0x50.
- R2: Register fields read back as follows. The format bit is bit 8 of 0x40, where 0 selects Clause 22 and 1 selects Clause 45. The port address is bits 12:8 of 0x44 and the register or device number is bits 4:0 of 0x44. The write value is bits 15:0 of 0x48. Any bit outside these fields reads 0.
- R3: A Clause 22 write frame is started by a write to 0x50 with bit 8 set and access code (bits 1:0) equal to 1. On MDIO it sends 32 ones, then 01, then 01, then the port address and the register number (5 bits each, MSB first), then turnaround 10, then the write value MSB first.
- R4: A Clause 22 read frame uses access code 0 and sends 32 ones, 01, 10, the port address and the register number. The master releases MDIO (output enable 0) for the 2 turnaround bits and all 16 data bits. It samples the 16 data bits on rising MDC, MSB first, and the result then reads at 0x4C bits 15:0.
- R5: A Clause 45 address frame (access code 0) sends 32 ones, 00, 00, the port address and the device number, then turnaround 10, then the write value as the register address.
- R6: A Clause 45 write frame (access code 1) sends 32 ones, 00, 01, the port address and the device number, then turnaround 10, then the write value.
- R7: A Clause 45 read frame (access code 2) sends 32 ones, 00, 11, the port address and the device number. It releases MDIO for the last 18 bits and captures the read value into 0x4C.
- R8: A command with an undefined code starts no frame. The undefined codes are 2 and 3 in Clause 22, and 3 in Clause 45. A write to 0x50 with bit 8 clear also starts no frame. In all of these cases busy stays 0 and MDC stays low.
- R9: Busy (bit 16 of 0x50) reads 1 from the cycle after the start write for exactly 64×DIV system clock cycles. It clears on the MDC falling edge that follows the 64th rising edge.
- R10: A start write while busy is ignored. The running frame is unchanged, it ends at its original time, and no second frame follows.
- R11: MDC has a period of DIV system clocks while busy, and is low whenever busy is 0. The MDIO output enable is never 1 while idle.
- R12: The MDIO output changes only on a falling MDC edge or at a frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_addr | input | BUS_AW | Register byte offset |
| bus_wdata | input | 32 | Register write value |
| bus_rdata | output | 32 | Register read value for bus_addr (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable (1 = master drives) |
| mdio_i | input | 1 | MDIO input from the pad |

## Verification
Suppose the bit counter or the shift register holds a wrong value. The captured frame then differs from the expected bit pattern within one MDC period of the fault. A wrong format or access-code decode shows in the start and opcode bits 33 to 36 bit periods after the start. A wrong turnaround or release decision shows in the output-enable pattern of the last 18 bits. A fault in the capture path shows at 0x4C as soon as busy clears. A fault in the end-of-frame logic shows in the measured busy length, which must be exactly 64×DIV cycles. It also shows as extra MDC edges counted after the frame.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
    localparam int FRAME_BITS = 64;
    localparam int PRE_BITS   = 32;
    localparam int DATA_W     = 16;
    localparam int FIELD_W    = 5;

    localparam logic [7:0] OFF_MODE  = 8'h40;
    localparam logic [7:0] OFF_ADDR  = 8'h44;
    localparam logic [7:0] OFF_WDATA = 8'h48;
    localparam logic [7:0] OFF_RDATA = 8'h4C;
    localparam logic [7:0] OFF_CMD   = 8'h50;

    typedef enum logic [1:0] {
        OP_C45_ADR = 2'b00,
        OP_WR      = 2'b01,
        OP_C22_RD  = 2'b10,
        OP_C45_RD  = 2'b11
    } frame_op_e;

    function automatic frame_op_e pick_op(input logic c45, input logic [1:0] code);
        if (!c45) return (code == 2'd0) ? OP_C22_RD : OP_WR;
        case (code)
            2'd0:    return OP_C45_ADR;
            2'd1:    return OP_WR;
            default: return OP_C45_RD;
        endcase
    endfunction
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
    parameter int DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic mdc_o,
    output logic rise_o,
    output logic fall_o
);
    localparam int HALF = DIV / 2;
    localparam int CW   = $clog2(HALF) + 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          mdc;
    } div_t;

    div_t q, d;
    logic wrap;

    assign wrap = (q.cnt == CW'(HALF - 1));

    always_comb begin
        d = q;
        if (!en_i) begin
            d = '0;
        end else if (wrap) begin
            d.cnt = '0;
            d.mdc = !q.mdc;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign mdc_o  = q.mdc;
    assign rise_o = en_i && wrap && !q.mdc;
    assign fall_o = en_i && wrap && q.mdc;

    // R11: an MDC level change is always announced by the matching strobe
    p_mdc_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdc_o) |-> $past(rise_o));
endmodule

// File: rtl/mdio_frame_shift.sv
module mdio_frame_shift #(
    parameter int FRAME_BITS = 64,
    parameter int DATA_W     = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic                  rd_i,
    input  logic [FRAME_BITS-1:0] frame_i,
    input  logic                  rise_i,
    input  logic                  fall_i,
    input  logic                  mdio_i,
    output logic                  busy_o,
    output logic                  mdio_o,
    output logic                  mdio_oe,
    output logic                  done_o,
    output logic [DATA_W-1:0]     cap_o
);
    localparam int IDX_W   = $clog2(FRAME_BITS);
    localparam int TA_POS  = FRAME_BITS - DATA_W - 2;
    localparam int DAT_POS = TA_POS + 2;

    typedef struct packed {
        logic                  busy;
        logic                  tail;
        logic                  rd;
        logic                  done;
        logic [IDX_W-1:0]      idx;
        logic [FRAME_BITS-1:0] sh;
        logic [DATA_W-1:0]     cap;
    } shf_t;

    shf_t q, d;

    always_comb begin
        d = q;
        d.done = 1'b0;
        if (!q.busy) begin
            if (start_i) begin
                d.busy = 1'b1;
                d.tail = 1'b0;
                d.rd   = rd_i;
                d.idx  = '0;
                d.sh   = frame_i;
            end
        end else begin
            if (rise_i) begin
                if (q.rd && q.idx >= IDX_W'(DAT_POS))
                    d.cap = {q.cap[DATA_W-2:0], mdio_i};
                if (q.idx == IDX_W'(FRAME_BITS - 1)) begin
                    d.tail = 1'b1;
                    d.done = q.rd;
                end
            end
            if (fall_i) begin
                if (q.tail) begin
                    d.busy = 1'b0;
                    d.tail = 1'b0;
                end else begin
                    d.idx = q.idx + 1'b1;
                    d.sh  = {q.sh[FRAME_BITS-2:0], 1'b1};
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy_o  = q.busy;
    assign mdio_o  = q.sh[FRAME_BITS-1];
    assign mdio_oe = q.busy && !(q.rd && q.idx >= IDX_W'(TA_POS));
    assign done_o  = q.done;
    assign cap_o   = q.cap;

    // R12: output bit moves only on a falling MDC strobe or a frame load
    p_shift_on_fall_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mdio_o) |-> ($past(fall_i) || $past(start_i)));

    // R9: an accepted start makes the engine busy at bit 0
    p_launch_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> (busy_o && q.idx == '0));
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
    import mdio_mgmt_pkg::*;
#(
    parameter int DIV    = 8,
    parameter int BUS_AW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_en,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);
    typedef struct packed {
        logic               c45;
        logic [FIELD_W-1:0] port;
        logic [FIELD_W-1:0] num;
        logic [DATA_W-1:0]  wval;
        logic [DATA_W-1:0]  rval;
    } regs_t;

    regs_t q, d;

    logic                  eng_busy, eng_done, rise, fall;
    logic [DATA_W-1:0]     eng_cap;
    logic [FRAME_BITS-1:0] frame;
    logic                  launch, is_rd, code_ok, start_req;
    logic [1:0]            code;
    frame_op_e             op;
    logic [7:0]            off;

    assign off       = 8'(bus_addr);
    assign code      = bus_wdata[1:0];
    assign start_req = bus_wr_en && (off == OFF_CMD) && bus_wdata[8];
    assign code_ok   = q.c45 ? (code != 2'd3) : (code[1] == 1'b0);
    assign launch    = start_req && code_ok && !eng_busy;
    assign op        = pick_op(q.c45, code);
    assign is_rd     = (op == OP_C22_RD) || (op == OP_C45_RD);
    assign frame     = {{PRE_BITS{1'b1}}, (q.c45 ? 2'b00 : 2'b01), op, q.port, q.num,
                        (is_rd ? 2'b11 : 2'b10), (is_rd ? {DATA_W{1'b1}} : q.wval)};

    always_comb begin
        d = q;
        if (bus_wr_en) begin
            case (off)
                OFF_MODE:  d.c45  = bus_wdata[8];
                OFF_ADDR:  begin
                    d.port = bus_wdata[8 +: FIELD_W];
                    d.num  = bus_wdata[FIELD_W-1:0];
                end
                OFF_WDATA: d.wval = bus_wdata[DATA_W-1:0];
                default:   ;
            endcase
        end
        if (eng_done) d.rval = eng_cap;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        case (off)
            OFF_MODE:  bus_rdata = {23'd0, q.c45, 8'd0};
            OFF_ADDR:  bus_rdata = {19'd0, q.port, 3'd0, q.num};
            OFF_WDATA: bus_rdata = {16'd0, q.wval};
            OFF_RDATA: bus_rdata = {16'd0, q.rval};
            OFF_CMD:   bus_rdata = {15'd0, eng_busy, 16'd0};
            default:   bus_rdata = '0;
        endcase
    end

    mdio_clk_div #(.DIV(DIV)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (eng_busy),
        .mdc_o  (mdc),
        .rise_o (rise),
        .fall_o (fall)
    );

    mdio_frame_shift #(.FRAME_BITS(FRAME_BITS), .DATA_W(DATA_W)) u_shf (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (launch),
        .rd_i    (is_rd),
        .frame_i (frame),
        .rise_i  (rise),
        .fall_i  (fall),
        .mdio_i  (mdio_i),
        .busy_o  (eng_busy),
        .mdio_o  (mdio_o),
        .mdio_oe (mdio_oe),
        .done_o  (eng_done),
        .cap_o   (eng_cap)
    );

    // R11: MDC is low whenever no frame runs
    p_mdc_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !eng_busy |-> !mdc);

    // R11: the pad is never driven while idle
    p_oe_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mdio_oe |-> eng_busy);

    // R4: read data register only changes when a read frame completes
    p_rval_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !eng_done |=> $stable(q.rval));
endmodule

// File: tb/mdio_mgmt_master_test.sv
`timescale 1ns/1ps
module mdio_mgmt_master_test;
    localparam int DIV = 4;
    localparam int FRAME_CYC = 64 * DIV;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr_en = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int compared = 0;
    int mismatched = 0;
    int cyc = 0;
    int bitn = 0;
    bit finished = 0;
    logic [63:0] cap = '0;
    logic [63:0] oecap = '0;
    logic [15:0] resp = '0;
    logic [15:0] last_rd = '0;

    mdio_mgmt_master #(.DIV(DIV), .BUS_AW(8)) uut (
        .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // PHY model: record driven bits on rising MDC, answer reads on falling MDC
    always @(posedge mdc) begin
        if (bitn < 64) begin
            cap[63 - bitn]   = mdio_o;
            oecap[63 - bitn] = mdio_oe;
        end
        bitn = bitn + 1;
    end
    always @(negedge mdc) begin
        if (bitn >= 48 && bitn < 64) mdio_i = resp[63 - bitn];
        else                         mdio_i = 1'b1;
    end

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        compared++;
        if (got !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] v);
        @(negedge clk);
        bus_wr_en = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_addr = a;
        #0.5;
        v = bus_rdata;
    endtask

    function automatic logic [63:0] exp_frame(input logic c45, input logic [1:0] code,
                                              input logic [4:0] port, input logic [4:0] num,
                                              input logic [15:0] wv);
        logic [1:0] op;
        logic rd;
        if (c45) op = (code == 2'd0) ? 2'b00 : (code == 2'd1) ? 2'b01 : 2'b11;
        else     op = (code == 2'd0) ? 2'b10 : 2'b01;
        rd = (op == 2'b10) || (op == 2'b11);
        return {32'hFFFF_FFFF, (c45 ? 2'b00 : 2'b01), op, port, num,
                (rd ? 2'b11 : 2'b10), (rd ? 16'hFFFF : wv)};
    endfunction

    // returns busy length in cycles; optionally injects a second start mid-frame
    task automatic run_frame(input string tag, input logic c45, input logic [1:0] code,
                             input logic [4:0] port, input logic [4:0] num,
                             input logic [15:0] wv, input logic [15:0] rv, input bit inject);
        logic [63:0] ef, mask;
        logic [31:0] r;
        int c0, n;
        bit rd;
        bus_write(8'h40, {23'd0, c45, 8'd0});
        bus_write(8'h44, {19'd0, port, 3'd0, num});
        bus_write(8'h48, {16'd0, wv});
        resp = rv; bitn = 0; cap = '0; oecap = '0;
        bus_write(8'h50, {23'd0, 1'b1, 6'd0, code});
        c0 = cyc;
        if (inject) begin
            repeat (40) @(negedge clk);
            bus_write(8'h50, {23'd0, 1'b1, 6'd0, code ^ 2'd1});
        end
        n = 0;
        forever begin
            bus_addr = 8'h50; #0.5;
            if (!bus_rdata[16] || n > 100000) break;
            @(negedge clk); n++;
        end
        check({tag, " R9 busy length"}, 64'(cyc - c0), 64'(FRAME_CYC));
        rd = c45 ? (code == 2'd2) : (code == 2'd0);
        ef   = exp_frame(c45, code, port, num, wv);
        mask = rd ? 64'hFFFF_FFFF_FFFC_0000 : 64'hFFFF_FFFF_FFFF_FFFF;
        check({tag, " frame bits"}, cap & mask, ef & mask);
        check({tag, " R4 R7 output enable pattern"}, oecap, mask);
        repeat (2 * DIV) @(negedge clk);
        check({tag, " R10 R11 MDC rises per frame"}, 64'(bitn), 64'd64);
        if (rd) last_rd = rv;
        bus_read(8'h4C, r);
        check({tag, " R4 R7 read data register"}, 64'(r), 64'(last_rd));
    endtask

    task automatic no_launch(input string tag, input logic c45, input logic [31:0] cmd);
        logic [31:0] r;
        bit moved;
        bus_write(8'h40, {23'd0, c45, 8'd0});
        bitn = 0;
        bus_write(8'h50, cmd);
        moved = 0;
        for (int i = 0; i < 3 * DIV; i++) begin
            bus_read(8'h50, r);
            if (r[16] || mdc) moved = 1;
        end
        check({tag, " R8 no frame started"}, 64'({moved, 8'(bitn)}), 64'd0);
    endtask

    initial begin
        logic [31:0] r;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        bus_read(8'h40, r); check("R1 mode", 64'(r), 64'd0);
        bus_read(8'h44, r); check("R1 addr", 64'(r), 64'd0);
        bus_read(8'h48, r); check("R1 wdata", 64'(r), 64'd0);
        bus_read(8'h4C, r); check("R1 rdata", 64'(r), 64'd0);
        bus_read(8'h50, r); check("R1 cmd", 64'(r), 64'd0);
        check("R1 mdc/oe idle", 64'({mdc, mdio_oe}), 64'd0);

        // R2 field readback
        bus_write(8'h40, 32'hFFFF_FFFF); bus_read(8'h40, r); check("R2 mode field", 64'(r), 64'h100);
        bus_write(8'h44, 32'hFFFF_FFFF); bus_read(8'h44, r); check("R2 addr fields", 64'(r), 64'h1F1F);
        bus_write(8'h48, 32'hFFFF_FFFF); bus_read(8'h48, r); check("R2 wdata field", 64'(r), 64'hFFFF);

        // directed frames
        run_frame("R3 c22 write", 1'b0, 2'd1, 5'h15, 5'h0A, 16'hA55A, 16'h0000, 0);
        run_frame("R4 c22 read",  1'b0, 2'd0, 5'h01, 5'h1F, 16'h1234, 16'hC3A5, 0);
        run_frame("R5 c45 addr",  1'b1, 2'd0, 5'h1F, 5'h03, 16'h8001, 16'h0000, 0);
        run_frame("R6 c45 write", 1'b1, 2'd1, 5'h00, 5'h07, 16'h0F0F, 16'h0000, 0);
        run_frame("R7 c45 read",  1'b1, 2'd2, 5'h0C, 5'h1E, 16'h0000, 16'h8E71, 0);
        run_frame("R4 c22 read zeros", 1'b0, 2'd0, 5'h00, 5'h00, 16'h0000, 16'h0000, 0);

        // R8 undefined codes and missing start bit
        no_launch("R8 c22 code2", 1'b0, 32'h0000_0102);
        no_launch("R8 c22 code3", 1'b0, 32'h0000_0103);
        no_launch("R8 c45 code3", 1'b1, 32'h0000_0103);
        no_launch("R8 no start bit", 1'b0, 32'h0000_0001);

        // R10 start while busy
        run_frame("R10 start while busy", 1'b0, 2'd1, 5'h0B, 5'h11, 16'hBEEF, 16'h0000, 1);

        // random mix
        for (int k = 0; k < 20; k++) begin
            logic c45;
            logic [1:0] code;
            c45  = 1'($urandom_range(0, 1));
            code = c45 ? 2'($urandom_range(0, 2)) : 2'($urandom_range(0, 1));
            run_frame("R3 R4 R5 R6 R7 random", c45, code, 5'($urandom), 5'($urandom),
                      16'($urandom), 16'($urandom), 0);
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            compared++; mismatched++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule